// File: doc/BRIEF.md
# Dual Lookup-Table Logic Slice

This block models one programmable logic slice built around two four-input lookup tables, F and G, each addressed by its own four select inputs. Before the slice starts running, a configuration port loads each table's sixteen content bits and its personality: plain logic, a 16x1 synchronous RAM, or a 16-bit shift register. Whatever the personality, a table's output is the content bit picked by its four inputs.

Each table feeds a small arithmetic stage. The table output either passes the incoming carry on or replaces it with a bypass input, and an XOR of the table output with the carry-in forms a sum bit. The F stage takes the slice carry-in, and the G stage takes F's carry-out. A select input merges the two table outputs into one combined result. Two output storage elements follow. X stores F's sum bit and Y stores the combined result. Each has its own enable, and configuration sets each one to act as an edge-triggered flip-flop or as a latch that is open while the clock is high.

Top module: `lut_slice`

## Requirements
- R1: Synchronous active-high reset clears both tables to all-zero logic personality, clears both register-mode bits, and clears `xq` and `yq`.
- R2: When `run` is low, a `cfg_we` pulse with `cfg_sel`=0 (F) or 1 (G) loads that table's personality from `cfg_mode` (0 logic, 1 RAM, 2 shift, 3 acts as logic) and its contents from `cfg_data`. With `cfg_sel`=2, the pulse loads the register modes from `cfg_data[1:0]`: bit 0 for X and bit 1 for Y, where 1 selects latch. In logic personality, the table output equals content bit number `f_in` (or `g_in`).
- R3: While `run` is high, `cfg_we` has no effect on contents, personalities or register modes.
- R4: In RAM personality, with `run` high and the write enable high, a rising edge stores the data input at the address on the table inputs, and reading is combinational.
- R5: In shift personality, with `run` high, each rising edge with the enable high moves the contents one place toward the top and puts the serial input into bit 0. With the enable low, the contents do not move. The output is the bit addressed by the table inputs.
- R6: In logic personality, the write enable and data input leave the contents unchanged.
- R7: Each stage's sum equals table output XOR carry-in. Its carry-out equals carry-in when the table output is 1, and the bypass input when the table output is 0.
- R8: G's carry-in is F's carry-out, and `carry_out` is G's carry-out.
- R9: `comb_out` is F's table output when `comb_sel` is 0 and G's when it is 1.
- R10: In flip-flop mode, a register takes its data on a rising edge with its enable high and holds when the enable is low. X's data is `f_sum` and Y's is `comb_out`.
- R11: In latch mode, a register follows its data while `clk` is high and the enable is high, and holds while `clk` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Slice running; blocks configuration |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target: 0 F, 1 G, 2 register modes |
| cfg_mode | input | 2 | Table personality to load |
| cfg_data | input | 16 | Table contents or register-mode bits |
| f_in | input | 4 | F table select inputs |
| g_in | input | 4 | G table select inputs |
| f_we | input | 1 | F write / shift enable |
| g_we | input | 1 | G write / shift enable |
| f_di | input | 1 | F RAM data / serial input |
| g_di | input | 1 | G RAM data / serial input |
| carry_in | input | 1 | Carry into the F stage |
| f_byp | input | 1 | F carry bypass input |
| g_byp | input | 1 | G carry bypass input |
| comb_sel | input | 1 | Combining multiplexer select |
| x_ce | input | 1 | X register enable |
| y_ce | input | 1 | Y register enable |
| f_sum | output | 1 | F sum bit |
| g_sum | output | 1 | G sum bit |
| carry_out | output | 1 | Carry out of the G stage |
| comb_out | output | 1 | Combined table output |
| xq | output | 1 | X register output |
| yq | output | 1 | Y register output |

## Verification
The logic path is driven by a vector table in which F holds a four-input AND and G a four-input OR. The vectors place inputs on the single matching address and off it. Carry-in and bypass values are varied so that, in each stage, the propagated carry and the substituted bypass can be told apart, and the two multiplexer selects give different results. A RAM write is read back at the written address and at a neighbour, then a write with the enable low is tried. For the shift register, a 1-0-1 serial pattern is entered and probed at four addresses, and the probes are repeated after an edge with the enable low. Latch mode is probed mid-high-phase and mid-low-phase so that transparency and holding give opposite results.

// File: rtl/slice_pkg.sv
package slice_pkg;
  typedef enum logic [1:0] {
    TM_LOGIC = 2'd0,
    TM_RAM   = 2'd1,
    TM_SHIFT = 2'd2,
    TM_SPARE = 2'd3
  } tbl_mode_e;

  localparam logic [1:0] SEL_F   = 2'd0;
  localparam logic [1:0] SEL_G   = 2'd1;
  localparam logic [1:0] SEL_REG = 2'd2;
endpackage

// File: rtl/lut_cell.sv
module lut_cell
  import slice_pkg::*;
#(
  parameter int K = 4,
  localparam int DEPTH = 1 << K
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             cfg_load,
  input  tbl_mode_e        cfg_mode,
  input  logic [DEPTH-1:0] cfg_bits,
  input  logic [K-1:0]     addr,
  input  logic             we,
  input  logic             di,
  output logic             dout
);
  tbl_mode_e        mode_q;
  logic [DEPTH-1:0] tbl;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= TM_LOGIC;
      tbl    <= '0;
    end else if (!run) begin
      if (cfg_load) begin
        mode_q <= cfg_mode;
        tbl    <= cfg_bits;
      end
    end else if (we) begin
      case (mode_q)
        TM_RAM:   tbl[addr] <= di;
        TM_SHIFT: tbl <= {tbl[DEPTH-2:0], di};
        default:  ;
      endcase
    end
  end

  assign dout = tbl[addr];

  // R4: RAM write lands at the addressed bit
  a_r4_ram_write: assert property (@(posedge clk) disable iff (rst)
    (run && mode_q == TM_RAM && we) |=> tbl[$past(addr)] == $past(di));

  // R5: shift moves by one place with serial input at bit 0
  a_r5_shift_step: assert property (@(posedge clk) disable iff (rst)
    (run && mode_q == TM_SHIFT && we) |=>
      (tbl[0] == $past(di)) && (tbl[DEPTH-1:1] == $past(tbl[DEPTH-2:0])));

  // R3: personality frozen while running
  a_r3_mode_frozen: assert property (@(posedge clk) disable iff (rst)
    run |=> mode_q == $past(mode_q));

  // R6: logic personality keeps contents while running
  a_r6_logic_hold: assert property (@(posedge clk) disable iff (rst)
    (run && mode_q == TM_LOGIC) |=> $stable(tbl));
endmodule

// File: rtl/carry_cell.sv
module carry_cell (
  input  logic lut,
  input  logic cin,
  input  logic byp,
  output logic sum,
  output logic cout
);
  assign sum  = lut ^ cin;
  assign cout = lut ? cin : byp;
endmodule

// File: rtl/out_reg.sv
module out_reg #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         latch_mode,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] ff_q;
  logic [W-1:0] lat_q;

  always_ff @(posedge clk) begin
    if (rst)     ff_q <= '0;
    else if (ce) ff_q <= d;
  end

  always_latch begin
    if (rst)            lat_q = '0;
    else if (clk && ce) lat_q = d;
  end

  assign q = latch_mode ? lat_q : ff_q;

  // R10: enabled edge captures the data
  a_r10_ff_capture: assert property (@(posedge clk) disable iff (rst)
    ce |=> ff_q == $past(d));
endmodule

// File: rtl/lut_slice.sv
module lut_slice
  import slice_pkg::*;
#(
  parameter int K = 4,
  localparam int DEPTH = 1 << K
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [1:0]       cfg_mode,
  input  logic [DEPTH-1:0] cfg_data,
  input  logic [K-1:0]     f_in,
  input  logic [K-1:0]     g_in,
  input  logic             f_we,
  input  logic             g_we,
  input  logic             f_di,
  input  logic             g_di,
  input  logic             carry_in,
  input  logic             f_byp,
  input  logic             g_byp,
  input  logic             comb_sel,
  input  logic             x_ce,
  input  logic             y_ce,
  output logic             f_sum,
  output logic             g_sum,
  output logic             carry_out,
  output logic             comb_out,
  output logic             xq,
  output logic             yq
);
  localparam int NT = 2;

  logic [NT-1:0][K-1:0] addr_a;
  logic [NT-1:0]        we_a, di_a, byp_a, lut_a, cin_a, cout_a, sum_a, load_a;
  logic [NT-1:0]        ce_a, d_a, q_a;
  logic [NT-1:0]        latch_q;

  assign addr_a = {g_in, f_in};
  assign we_a   = {g_we, f_we};
  assign di_a   = {g_di, f_di};
  assign byp_a  = {g_byp, f_byp};
  assign cin_a  = {cout_a[0], carry_in};

  always_ff @(posedge clk) begin
    if (rst)                                  latch_q <= '0;
    else if (!run && cfg_we && cfg_sel == SEL_REG) latch_q <= cfg_data[NT-1:0];
  end

  for (genvar t = 0; t < NT; t++) begin : g_tbl
    assign load_a[t] = cfg_we && (cfg_sel == 2'(t));
    lut_cell #(.K(K)) u_cell (
      .clk      (clk),
      .rst      (rst),
      .run      (run),
      .cfg_load (load_a[t]),
      .cfg_mode (tbl_mode_e'(cfg_mode)),
      .cfg_bits (cfg_data),
      .addr     (addr_a[t]),
      .we       (we_a[t]),
      .di       (di_a[t]),
      .dout     (lut_a[t])
    );
    carry_cell u_carry (
      .lut  (lut_a[t]),
      .cin  (cin_a[t]),
      .byp  (byp_a[t]),
      .sum  (sum_a[t]),
      .cout (cout_a[t])
    );
  end

  assign comb_out  = comb_sel ? lut_a[1] : lut_a[0];
  assign f_sum     = sum_a[0];
  assign g_sum     = sum_a[1];
  assign carry_out = cout_a[1];

  assign ce_a = {y_ce, x_ce};
  assign d_a  = {comb_out, f_sum};

  for (genvar r = 0; r < NT; r++) begin : g_reg
    out_reg #(.W(1)) u_reg (
      .clk        (clk),
      .rst        (rst),
      .latch_mode (latch_q[r]),
      .ce         (ce_a[r]),
      .d          (d_a[r]),
      .q          (q_a[r])
    );
  end

  assign xq = q_a[0];
  assign yq = q_a[1];

  // R3: register modes frozen while running
  a_r3_regmode_frozen: assert property (@(posedge clk) disable iff (rst)
    run |=> latch_q == $past(latch_q));

  // R1: reset clears register modes
  a_r1_reset_modes: assert property (@(posedge clk)
    rst |=> latch_q == '0);
endmodule

// File: tb/lut_slice_bench.sv
`timescale 1ns/1ps
module lut_slice_bench;
  logic clk = 1'b0;
  logic rst, run, cfg_we;
  logic [1:0] cfg_sel, cfg_mode;
  logic [15:0] cfg_data;
  logic [3:0] f_in, g_in;
  logic f_we, g_we, f_di, g_di, carry_in, f_byp, g_byp, comb_sel, x_ce, y_ce;
  logic f_sum, g_sum, carry_out, comb_out, xq, yq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  lut_slice u_lut_slice (
    .clk(clk), .rst(rst), .run(run), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_mode(cfg_mode), .cfg_data(cfg_data), .f_in(f_in), .g_in(g_in),
    .f_we(f_we), .g_we(g_we), .f_di(f_di), .g_di(g_di), .carry_in(carry_in),
    .f_byp(f_byp), .g_byp(g_byp), .comb_sel(comb_sel), .x_ce(x_ce), .y_ce(y_ce),
    .f_sum(f_sum), .g_sum(g_sum), .carry_out(carry_out), .comb_out(comb_out),
    .xq(xq), .yq(yq)
  );

  typedef struct packed {
    logic [3:0] fi;
    logic [3:0] gi;
    logic       sel;
    logic       cin;
    logic       fb;
    logic       gb;
    logic       e_comb;
    logic       e_fsum;
    logic       e_gsum;
    logic       e_cout;
  } vec_t;

  // F = AND of its inputs (16'h8000), G = OR of its inputs (16'hFFFE)
  localparam vec_t VECS [8] = '{
    '{4'hF, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    '{4'hF, 4'h0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    '{4'h7, 4'h3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    '{4'h7, 4'h3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    '{4'hE, 4'h8, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    '{4'hF, 4'hF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    '{4'h0, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{4'hF, 4'h1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [1:0] mode, input logic [15:0] data);
    cfg_we = 1'b1; cfg_sel = sel; cfg_mode = mode; cfg_data = data;
    tick();
    cfg_we = 1'b0;
  endtask

  initial begin
    #500us;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; run = 1'b0; cfg_we = 1'b0; cfg_sel = 2'd0; cfg_mode = 2'd0;
    cfg_data = '0; f_in = '0; g_in = '0; f_we = 1'b0; g_we = 1'b0;
    f_di = 1'b0; g_di = 1'b0; carry_in = 1'b0; f_byp = 1'b0; g_byp = 1'b0;
    comb_sel = 1'b0; x_ce = 1'b0; y_ce = 1'b0;
    tick(); tick();
    rst = 1'b0;
    f_in = 4'hF; g_in = 4'hF;
    #1;
    chk("R1 reset f table zero", f_sum, 1'b0);
    chk("R1 reset g table zero", g_sum, 1'b0);
    chk("R1 reset xq", xq, 1'b0);
    chk("R1 reset yq", yq, 1'b0);

    @(negedge clk);
    cfg(2'd0, 2'd0, 16'h8000);
    cfg(2'd1, 2'd0, 16'hFFFE);
    run = 1'b1;

    for (int i = 0; i < 8; i++) begin
      f_in = VECS[i].fi; g_in = VECS[i].gi; comb_sel = VECS[i].sel;
      carry_in = VECS[i].cin; f_byp = VECS[i].fb; g_byp = VECS[i].gb;
      #1;
      chk($sformatf("R2/R9 comb vec %0d", i), comb_out, VECS[i].e_comb);
      chk($sformatf("R7 f_sum vec %0d", i), f_sum, VECS[i].e_fsum);
      chk($sformatf("R8 g_sum vec %0d", i), g_sum, VECS[i].e_gsum);
      chk($sformatf("R8 carry_out vec %0d", i), carry_out, VECS[i].e_cout);
      @(negedge clk);
    end

    // R3: configuration ignored while running
    carry_in = 1'b0; comb_sel = 1'b0; f_in = 4'hF;
    cfg(2'd0, 2'd0, 16'h0000);
    #1 chk("R3 cfg blocked while run", comb_out, 1'b1);
    @(negedge clk);

    // R6: write enable in logic mode does nothing
    f_we = 1'b1; f_di = 1'b0;
    tick();
    f_we = 1'b0;
    #1 chk("R6 logic ignores we", comb_out, 1'b1);

    // R10: flip-flop behaviour on X (d = f_sum = 1)
    @(negedge clk);
    tick();
    #1 chk("R10 no capture without ce", xq, 1'b0);
    @(negedge clk);
    x_ce = 1'b1;
    tick();
    x_ce = 1'b0;
    #1 chk("R10 capture with ce", xq, 1'b1);
    @(negedge clk);
    f_in = 4'h0;
    tick();
    #1 chk("R10 hold without ce", xq, 1'b1);

    // R4: G as RAM, F as shift register
    @(negedge clk);
    run = 1'b0;
    cfg(2'd1, 2'd1, 16'h0000);
    cfg(2'd0, 2'd2, 16'h0000);
    run = 1'b1;
    g_in = 4'd5; g_di = 1'b1; g_we = 1'b1;
    tick();
    g_we = 1'b0; g_di = 1'b0; comb_sel = 1'b1;
    #1 chk("R4 ram read written bit", comb_out, 1'b1);
    g_in = 4'd4;
    #1 chk("R4 ram neighbour untouched", comb_out, 1'b0);
    @(negedge clk);
    g_in = 4'd5;
    tick();
    #1 chk("R4 no write without we", comb_out, 1'b1);

    // R5: shift pattern 1,0,1
    @(negedge clk);
    comb_sel = 1'b0; f_we = 1'b1;
    f_di = 1'b1; tick();
    f_di = 1'b0; tick();
    f_di = 1'b1; tick();
    f_we = 1'b0; f_di = 1'b0;
    f_in = 4'd0; #1 chk("R5 shift bit0", comb_out, 1'b1);
    f_in = 4'd1; #1 chk("R5 shift bit1", comb_out, 1'b0);
    f_in = 4'd2; #1 chk("R5 shift bit2", comb_out, 1'b1);
    f_in = 4'd3; #1 chk("R5 shift bit3", comb_out, 1'b0);
    @(negedge clk);
    f_di = 1'b1;
    tick();
    f_in = 4'd0; #1 chk("R5 hold without enable bit0", comb_out, 1'b1);
    f_in = 4'd3; #1 chk("R5 hold without enable bit3", comb_out, 1'b0);

    // R11: Y in latch mode, d = comb_out from G RAM (addr 5 = 1, addr 4 = 0)
    @(negedge clk);
    run = 1'b0;
    cfg(2'd2, 2'd0, 16'h0002);
    run = 1'b1;
    comb_sel = 1'b1; g_in = 4'd4; y_ce = 1'b1;
    @(posedge clk);
    #1;
    chk("R11 latch open follows low", yq, 1'b0);
    g_in = 4'd5;
    #0.5 chk("R11 latch transparent while clk high", yq, 1'b1);
    @(negedge clk);
    #1 g_in = 4'd4;
    #0.5;
    chk("R11 comb changed", comb_out, 1'b0);
    chk("R11 latch holds while clk low", yq, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule